// File: doc/BRIEF.md
# Predicated Multicycle CPU Core

This block is a small 32-bit load/store processor core that walks through one fetch, decode and execute step per instruction. It talks to a synchronous, word-addressed memory over a single port. That port has an address, write data, a write strobe, a read strobe and read data, and the read data returns one cycle after the read strobe. Inside the core are sixteen registers, a four-bit condition register, an arithmetic unit and a small state machine. Register 0 always reads as zero, and register 15 is the program counter.

Every instruction carries a four-bit mask. The core ANDs that mask with the condition register. If the result is zero, the instruction is skipped and only the program counter advances. The counter is bumped before any result is written, so an arithmetic op or a load whose target is register 15 acts as a jump.

After reset the core sits halted. A pulse on `start` loads the program counter from `startAddr` and begins execution. The core stops when it runs a HALT.

Top module: `pred_cpu_core`

## Requirements
- R1: After reset the core is halted, drives neither memory strobe, and holds the condition register at 4'b1111, so the first instruction after start runs whatever its mask.
- R2: A `start` pulse loads the program counter with `startAddr`, clears `halted`, and the next memory read fetches from that address.
- R3: An instruction word is split as op [30:26], mask [25:22], target [21:18], first source [17:14], second source [13:10] and offset [9:0]; bit 31 is ignored. The offset is sign-extended. The ALU operands are the first source value and the second source value plus the offset.
- R4: When (condition register AND mask) is zero, the instruction has no effect except that the program counter increases by one.
- R5: Opcode 3 adds, 5 subtracts, 6 multiplies (low 32 bits) and 7 divides with the quotient rounded toward minus infinity. Division by zero gives 0 with flag V. Otherwise exactly one flag is set: bit0 M for negative, bit1 Z for zero, bit2 P for positive. Bit3 is V.
- R6: Only taken ADD, SUB, MUL and DIV write the condition register. LOAD (1), STORE (2) and HALT (0) leave it unchanged.
- R7: The program counter is incremented before write-back. A first source of r15 reads the address of the current instruction. An ADD/SUB/MUL/DIV or LOAD targeting r15 jumps to the written value. A STORE of r15 stores the incremented value.
- R8: LOAD reads memory at the ALU result and writes the returned word to the target register. It takes one more cycle than other instructions.
- R9: STORE writes the target register's value to memory at the ALU result.
- R10: Register 0 reads as zero, and ALU or LOAD writes to it are discarded.
- R11: HALT raises `halted`; while halted, neither memory strobe is driven until the next `start`.
- R12: Opcodes other than 0, 1, 2, 3, 5, 6 and 7 change no register or memory word, and only advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at `startAddr` |
| startAddr | input | ADDR_W | Initial program counter |
| memAddr | output | ADDR_W | Word address for fetch, load or store |
| memWdata | output | DATA_W | Store data |
| memWe | output | 1 | Memory write strobe |
| memRe | output | 1 | Memory read strobe; data returns next cycle |
| memRdata | input | DATA_W | Read data, valid the cycle after `memRe` |
| halted | output | 1 | Core is stopped |

## Verification
The assertions assume three things about the environment. The memory returns the addressed word exactly one cycle after `memRe`. `start` arrives as a single-cycle pulse. The words fetched from memory are instructions in the stated layout. The bench meets these by modelling a one-cycle-latency memory, pulsing `start` for one cycle just after each reset, and building every program with an encoder that follows the field layout. Results and flags are observed only through STORE instructions, including ones masked on a single flag, so all checks happen at the memory port.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);
  localparam int OFF_W  = 10;
  localparam int FLAG_W = 4;

  localparam logic [4:0] OP_HALT  = 5'd0;
  localparam logic [4:0] OP_LOAD  = 5'd1;
  localparam logic [4:0] OP_STORE = 5'd2;
  localparam logic [4:0] OP_ADD   = 5'd3;
  localparam logic [4:0] OP_SUB   = 5'd5;
  localparam logic [4:0] OP_MUL   = 5'd6;
  localparam logic [4:0] OP_DIV   = 5'd7;

  // condition bit positions (mask and register share them)
  localparam int F_NEG  = 0;
  localparam int F_ZERO = 1;
  localparam int F_POS  = 2;
  localparam int F_OVF  = 3;

  typedef struct packed {
    logic              rsvd;
    logic [4:0]        op;
    logic [FLAG_W-1:0] mask;
    logic [RIDX_W-1:0] tgt;
    logic [RIDX_W-1:0] src1;
    logic [RIDX_W-1:0] src2;
    logic [OFF_W-1:0]  off;
  } instr_t;

  typedef struct packed {
    logic start;   // load PC from start address
    logic fetch;   // read instruction at PC
    logic exec;    // instruction word present on read data
    logic loadWb;  // load data present on read data
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_MEM} state_e;

endpackage

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [4:0]        op,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] flags
);

  logic signed [W-1:0] sa, sb, quo, rem;
  logic divZero;

  assign sa = opA;
  assign sb = opB;

  always_comb begin
    res     = '0;
    quo     = '0;
    rem     = '0;
    divZero = 1'b0;
    case (op)
      OP_ADD, OP_LOAD, OP_STORE: res = opA + opB;
      OP_SUB: res = opA - opB;
      OP_MUL: res = opA * opB;
      OP_DIV: begin
        if (opB == '0) begin
          divZero = 1'b1;
        end else begin
          quo = sa / sb;
          rem = sa % sb;
          // round toward minus infinity
          res = (rem != '0 && (rem[W-1] != sb[W-1])) ? quo - W'(1) : quo;
        end
      end
      default: res = '0;
    endcase
  end

  always_comb begin
    flags = '0;
    if (divZero)          flags[F_OVF]  = 1'b1;
    else if (res == '0)   flags[F_ZERO] = 1'b1;
    else if (res[W-1])    flags[F_NEG]  = 1'b1;
    else                  flags[F_POS]  = 1'b1;
  end

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  output logic              taken,
  output logic              isLoad,
  output logic              isHalt
);

  localparam logic [RIDX_W-1:0] PC_IDX = RIDX_W'(NREG - 1);
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);

  logic [DATA_W-1:0] regQ [1:NREG-1];
  logic [FLAG_W-1:0] condQ;
  logic [RIDX_W-1:0] loadTgtQ;

  instr_t ir;
  logic [DATA_W-1:0] pcQ, pcNext, src1Val, src2Val, tgtVal, offExt, aluRes;
  logic [FLAG_W-1:0] aluFlags;
  logic isAlu, isStore, aluWb, unusedBits;

  assign ir         = memRdata[31:0];
  assign unusedBits = ir.rsvd;

  function automatic logic [DATA_W-1:0] readReg(input logic [RIDX_W-1:0] idx,
                                                input logic [DATA_W-1:0] rf [1:NREG-1]);
    return (idx == '0) ? '0 : rf[idx];
  endfunction

  assign pcQ     = regQ[PC_IDX];
  assign pcNext  = pcQ + ONE;
  assign src1Val = readReg(ir.src1, regQ);
  assign src2Val = readReg(ir.src2, regQ);
  assign tgtVal  = readReg(ir.tgt, regQ);
  assign offExt  = {{(DATA_W-OFF_W){ir.off[OFF_W-1]}}, ir.off};

  cpu_alu #(.W(DATA_W)) u_alu (
    .op   (ir.op),
    .opA  (src1Val),
    .opB  (src2Val + offExt),
    .res  (aluRes),
    .flags(aluFlags)
  );

  assign taken   = |(condQ & ir.mask);
  assign isLoad  = (ir.op == OP_LOAD);
  assign isStore = (ir.op == OP_STORE);
  assign isHalt  = (ir.op == OP_HALT);
  assign isAlu   = (ir.op == OP_ADD) || (ir.op == OP_SUB) ||
                   (ir.op == OP_MUL) || (ir.op == OP_DIV);
  assign aluWb   = ctrl.exec && taken && isAlu;

  assign memRe    = ctrl.fetch || (ctrl.exec && taken && isLoad);
  assign memWe    = ctrl.exec && taken && isStore;
  assign memAddr  = ctrl.fetch ? pcQ[ADDR_W-1:0] : aluRes[ADDR_W-1:0];
  // a stored PC is the already-incremented one
  assign memWdata = (ir.tgt == PC_IDX) ? pcNext : tgtVal;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < NREG; i++) regQ[i] <= '0;
    end else if (ctrl.start) begin
      regQ[PC_IDX] <= DATA_W'(startAddr);
    end else begin
      if (ctrl.exec) regQ[PC_IDX] <= pcNext;
      // later writes win over the PC increment
      if (aluWb && ir.tgt != '0) regQ[ir.tgt] <= aluRes;
      if (ctrl.loadWb && loadTgtQ != '0) regQ[loadTgtQ] <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      condQ    <= '1;
      loadTgtQ <= '0;
    end else begin
      if (aluWb) condQ <= aluFlags;
      if (ctrl.exec) loadTgtQ <= ir.tgt;
    end
  end

  p_skip_pc_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl.exec && !taken) |=> (pcQ == $past(pcQ) + ONE));

  p_cond_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !aluWb |=> (condQ == $past(condQ)));

  p_flag_single_r5: assert property (@(posedge clk) disable iff (rst)
    aluWb |=> ($countones(condQ) == 1));

  p_load_wb_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadWb |-> $past(ctrl.exec && taken && isLoad));

endmodule

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  logic  taken,
  input  logic  isLoad,
  input  logic  isHalt,
  output ctrl_t ctrl,
  output logic  halted
);

  state_e stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    if (start) begin
      stateNext = ST_FETCH;
    end else begin
      case (stateQ)
        ST_IDLE:  stateNext = ST_IDLE;
        ST_FETCH: stateNext = ST_EXEC;
        ST_EXEC: begin
          if (taken && isHalt)      stateNext = ST_IDLE;
          else if (taken && isLoad) stateNext = ST_MEM;
          else                      stateNext = ST_FETCH;
        end
        ST_MEM:   stateNext = ST_FETCH;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateNext;
  end

  assign ctrl.start  = start;
  assign ctrl.fetch  = !start && (stateQ == ST_FETCH);
  assign ctrl.exec   = !start && (stateQ == ST_EXEC);
  assign ctrl.loadWb = !start && (stateQ == ST_MEM);
  assign halted      = (stateQ == ST_IDLE);

  p_fetch_exec_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl.fetch |=> (stateQ == ST_EXEC));

endmodule

// File: rtl/pred_cpu_core.sv
module pred_cpu_core
  import cpu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [DATA_W-1:0] memRdata,
  output logic              halted
);

  ctrl_t ctrl;
  logic taken, isLoad, isHalt;

  cpu_control u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .taken (taken),
    .isLoad(isLoad),
    .isHalt(isHalt),
    .ctrl  (ctrl),
    .halted(halted)
  );

  cpu_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .startAddr(startAddr),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRe    (memRe),
    .taken    (taken),
    .isLoad   (isLoad),
    .isHalt   (isHalt)
  );

  p_halt_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!memRe && !memWe));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> !halted);

endmodule

// File: tb/tb_pred_cpu_core.sv
module tb_pred_cpu_core;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 16;
  localparam int NVEC   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ADDR_W-1:0] startAddr = '0;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memWdata, memRdata;
  logic memWe, memRe, halted;

  logic [31:0] mem [256];
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pred_cpu_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .start(start), .startAddr(startAddr),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .halted(halted)
  );

  // one-cycle-latency memory
  always @(posedge clk) begin
    if (memWe) mem[memAddr[7:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[7:0]];
  end

  localparam logic [4:0] V_OP [NVEC] = '{5'd3, 5'd3, 5'd3, 5'd5, 5'd5, 5'd6,
                                         5'd6, 5'd7, 5'd7, 5'd7, 5'd7, 5'd7};
  localparam int V_A   [NVEC] = '{5, -5, -10, 5, 3, -3, 0, 5, 12, 3, 12, -7};
  localparam int V_B   [NVEC] = '{3, 3, 10, 3, 5, 5, 22, 3, -3, 4, 0, 2};
  localparam int V_RES [NVEC] = '{8, -2, 0, 2, -2, -15, 0, 1, -4, 0, 0, -4};
  localparam logic [3:0] V_FL [NVEC] = '{4'b0100, 4'b0001, 4'b0010, 4'b0100,
                                         4'b0001, 4'b0001, 4'b0010, 4'b0100,
                                         4'b0001, 4'b0010, 4'b1000, 4'b0001};

  function automatic logic [31:0] enc(input logic [4:0] op, input logic [3:0] m,
                                      input logic [3:0] t, input logic [3:0] s1,
                                      input logic [3:0] s2, input int off);
    logic [31:0] o;
    o = off;
    return {1'b0, op, m, t, s1, s2, o[9:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
  endtask

  task automatic runProg(input logic [ADDR_W-1:0] sa);
    bit done;
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    start = 1'b1;
    startAddr = sa;
    @(negedge clk);
    start = 1'b0;
    done = 1'b0;
    for (int c = 0; c < 400 && !done; c++) begin
      @(negedge clk);
      if (halted) done = 1'b1;
    end
    check(done, "R11 halt reached", 32'(done), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [3:0] obs;
    clearMem();
    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(halted == 1'b1, "R1 halted after reset", 32'(halted), 32'd1);
    check(!memRe && !memWe, "R1 no access after reset", {memRe, memWe}, 32'd0);

    // table of ALU vectors (R5, R6, R8, R9)
    for (int v = 0; v < NVEC; v++) begin
      clearMem();
      mem[0] = enc(5'd1, 4'hF, 4'd1, 4'd0, 4'd0, 100);
      mem[1] = enc(5'd1, 4'hF, 4'd2, 4'd0, 4'd0, 101);
      mem[2] = enc(V_OP[v], 4'hF, 4'd3, 4'd1, 4'd2, 0);
      mem[3] = enc(5'd2, 4'hF, 4'd3, 4'd0, 4'd0, 102);
      for (int f = 0; f < 4; f++) mem[4+f] = enc(5'd2, 4'(1 << f), 4'd0, 4'd0, 4'd0, 103 + f);
      mem[8] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
      mem[100] = V_A[v];
      mem[101] = V_B[v];
      runProg('0);
      check(mem[102] == 32'(V_RES[v]), "R5 result", mem[102], 32'(V_RES[v]));
      for (int f = 0; f < 4; f++) obs[f] = (mem[103+f] == 32'd0);
      check(obs == V_FL[v], "R6 flags after op", 32'(obs), 32'(V_FL[v]));
    end

    // R1: first instruction runs even with mask V only
    clearMem();
    mem[0] = enc(5'd3, 4'b1000, 4'd1, 4'd0, 4'd0, 8);
    mem[1] = enc(5'd2, 4'hF, 4'd1, 4'd0, 4'd0, 102);
    mem[2] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    runProg('0);
    check(mem[102] == 32'd8, "R1 first instr executes", mem[102], 32'd8);

    // R4: skipped instruction
    clearMem();
    mem[0] = enc(5'd3, 4'hF, 4'd1, 4'd0, 4'd0, 7);
    mem[1] = enc(5'd3, 4'b0001, 4'd1, 4'd0, 4'd0, 9);
    mem[2] = enc(5'd2, 4'hF, 4'd1, 4'd0, 4'd0, 102);
    mem[3] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    runProg('0);
    check(mem[102] == 32'd7, "R4 predicate false skips", mem[102], 32'd7);

    // R3: negative offset and src2 plus offset
    clearMem();
    mem[0] = enc(5'd3, 4'hF, 4'd1, 4'd0, 4'd0, -3);
    mem[1] = enc(5'd2, 4'hF, 4'd1, 4'd0, 4'd0, 102);
    mem[2] = enc(5'd1, 4'hF, 4'd2, 4'd0, 4'd0, 100);
    mem[3] = enc(5'd5, 4'hF, 4'd3, 4'd2, 4'd2, 5);
    mem[4] = enc(5'd2, 4'hF, 4'd3, 4'd0, 4'd0, 103);
    mem[5] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    mem[100] = 32'd10;
    runProg('0);
    check(mem[102] == 32'hFFFF_FFFD, "R3 sign-extended offset", mem[102], 32'hFFFF_FFFD);
    check(mem[103] == 32'hFFFF_FFFB, "R3 src2 plus offset", mem[103], 32'hFFFF_FFFB);

    // R7: ALU jump through r15
    clearMem();
    mem[0] = enc(5'd3, 4'hF, 4'd1, 4'd0, 4'd0, 3);
    mem[1] = enc(5'd3, 4'hF, 4'd15, 4'd0, 4'd0, 4);
    mem[2] = enc(5'd3, 4'hF, 4'd1, 4'd0, 4'd0, 9);
    mem[3] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    mem[4] = enc(5'd2, 4'hF, 4'd1, 4'd0, 4'd0, 102);
    mem[5] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    runProg('0);
    check(mem[102] == 32'd3, "R7 jump via ALU write to r15", mem[102], 32'd3);

    // R2 and R7: start address, r15 as source, stored r15
    clearMem();
    mem[20] = enc(5'd3, 4'hF, 4'd2, 4'd15, 4'd0, 0);
    mem[21] = enc(5'd2, 4'hF, 4'd2, 4'd0, 4'd0, 102);
    mem[22] = enc(5'd2, 4'hF, 4'd15, 4'd0, 4'd0, 103);
    mem[23] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    runProg(16'd20);
    check(mem[102] == 32'd20, "R2 start address / R7 r15 source", mem[102], 32'd20);
    check(mem[103] == 32'd23, "R7 stored r15 is incremented", mem[103], 32'd23);

    // R8 and R7: LOAD into r15 jumps
    clearMem();
    mem[0] = enc(5'd1, 4'hF, 4'd15, 4'd0, 4'd0, 100);
    mem[1] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    mem[4] = enc(5'd3, 4'hF, 4'd1, 4'd0, 4'd0, 6);
    mem[5] = enc(5'd2, 4'hF, 4'd1, 4'd0, 4'd0, 102);
    mem[6] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    mem[100] = 32'd4;
    runProg('0);
    check(mem[102] == 32'd6, "R8 LOAD to r15 jumps", mem[102], 32'd6);

    // R6: LOAD leaves zero flag in place
    clearMem();
    mem[0] = enc(5'd3, 4'hF, 4'd1, 4'd0, 4'd0, 0);
    mem[1] = enc(5'd1, 4'hF, 4'd2, 4'd0, 4'd0, 100);
    mem[2] = enc(5'd2, 4'b0010, 4'd0, 4'd0, 4'd0, 103);
    mem[3] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    mem[100] = 32'd5;
    runProg('0);
    check(mem[103] == 32'd0, "R6 LOAD keeps condition", mem[103], 32'd0);

    // R10: r0 writes discarded
    clearMem();
    mem[0] = enc(5'd3, 4'hF, 4'd0, 4'd0, 4'd0, 5);
    mem[1] = enc(5'd2, 4'hF, 4'd0, 4'd0, 4'd0, 102);
    mem[2] = enc(5'd1, 4'hF, 4'd0, 4'd0, 4'd0, 100);
    mem[3] = enc(5'd2, 4'hF, 4'd0, 4'd0, 4'd0, 103);
    mem[4] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    mem[100] = 32'd7;
    runProg('0);
    check(mem[102] == 32'd0, "R10 ALU write to r0 ignored", mem[102], 32'd0);
    check(mem[103] == 32'd0, "R10 LOAD to r0 ignored", mem[103], 32'd0);

    // R12: undefined opcode has no effect
    clearMem();
    mem[0] = enc(5'd3, 4'hF, 4'd1, 4'd0, 4'd0, 3);
    mem[1] = enc(5'd4, 4'hF, 4'd1, 4'd0, 4'd0, 9);
    mem[2] = enc(5'd2, 4'hF, 4'd1, 4'd0, 4'd0, 102);
    mem[3] = enc(5'd0, 4'hF, 4'd0, 4'd0, 4'd0, 0);
    runProg('0);
    check(mem[102] == 32'd3, "R12 undefined opcode no-op", mem[102], 32'd3);

    // R11: quiet while halted
    begin
      int acc = 0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (memRe || memWe) acc++;
      end
      check(acc == 0 && halted, "R11 no access while halted", 32'(acc), 32'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule